// File: doc/BRIEF.md
# SPI Status Flag and Interrupt Unit

This block keeps the sticky status flags of an SPI peripheral: slave abort, mode fault, read overrun, write collision and transfer complete. The shift engine raises each flag with a one-cycle event pulse. Once a flag is set, only a fixed sequence of accesses on a simple register bus can clear it. Some flags clear on a status read alone. Others need a status read first and then a later access to the control or data register.

The block also holds the control fields that it needs. These are the interrupt enable and the transfer-length fields. From them it drives a level interrupt request and a decoded transfer length in bits. The bus has a select, a read strobe, a write strobe and a two-bit register address: 0 is status, 1 is control and 2 is data. A status read returns `status_o` as it stands in that cycle. That is the value before any clear the read itself causes.

Top module: `spi_flag_unit`

## Requirements
- R1: After reset all five flags are 0, `status_o` is 8'h00, `irq_o` is 0 and `xfer_len_o` is 8.
- R2: Status byte layout: bits 2:0 always read 0, bit 3 slave abort, bit 4 mode fault, bit 5 read overrun, bit 6 write collision, bit 7 transfer complete.
- R3: An event pulse sets its flag at the next clock edge. The flag then stays 1 until its clear sequence completes.
- R4: Slave abort and read overrun clear at the edge that ends a status read. The byte returned by that read still shows them as 1.
- R5: Mode fault clears only on a control-register write that follows a status read which saw it at 1. A control write with no such earlier read leaves it set.
- R6: Write collision and transfer complete clear only on a data-register read or write that follows a status read which saw them at 1. A data access with no such earlier read leaves them set.
- R7: A set event in the same cycle as a clearing access wins. The flag stays 1, and it needs a fresh status read before a later access can clear it.
- R8: `irq_o` is 1 exactly while control bit 7 is 1 and at least one of transfer complete or mode fault is 1. Slave abort, read overrun and write collision never raise it.
- R9: `xfer_len_o`: when control bit 2 is 1, control bits 11:8 = 4'b1000..4'b1111 give 8..15 and 4'b0000 gives 16. When control bit 2 is 0, or for codes 4'b0001..4'b0111, the length is 8.
- R10: A status read taken while a two-step flag is 0 does not arm it. If the flag is set afterwards, a following control or data access does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Bus select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register: 0 status, 1 control, 2 data |
| wdata_i | input | 16 | Write data (used for control writes) |
| ev_abort_i | input | 1 | Slave abort event pulse |
| ev_modf_i | input | 1 | Mode fault event pulse |
| ev_ovr_i | input | 1 | Read overrun event pulse |
| ev_wcol_i | input | 1 | Write collision event pulse |
| ev_done_i | input | 1 | Transfer complete event pulse |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request level |
| xfer_len_o | output | 5 | Decoded bits per transfer |

## Verification
A wrong armed bit shows up at the ports as a flag that stays set after its proper two-step sequence, or as a flag that clears on an access that should not clear it. Either shows in `status_o` one cycle after the second access. A flag register that takes its value from the wrong clear path makes `status_o` differ from the expected byte at the first edge after the offending access. Because `irq_o` follows the flags with no delay, the interrupt shows the same error in that same cycle. A wrong length decode shows up in `xfer_len_o` one cycle after the control write.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned CTRL_W = 16;
  localparam int unsigned LEN_W  = 5;
  localparam int unsigned NFLAG  = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT = 2'd0,
    REG_CTRL = 2'd1,
    REG_DATA = 2'd2
  } reg_sel_e;

  // flag index order equals status bit order starting at bit 3
  localparam int unsigned F_ABORT = 0;
  localparam int unsigned F_MODF  = 1;
  localparam int unsigned F_OVR   = 2;
  localparam int unsigned F_WCOL  = 3;
  localparam int unsigned F_DONE  = 4;

  localparam int unsigned CB_LEN_EN = 2;
  localparam int unsigned CB_IE     = 7;
  localparam int unsigned CB_LEN_LO = 8;
  localparam int unsigned LEN_CODE_W = 4;
endpackage

// File: rtl/spi_flag_cell.sv
module spi_flag_cell #(
  parameter bit TWO_STEP = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic second_i,
  output logic flag_o
);
  logic flag_q, armed_q, clr;

  generate
    if (TWO_STEP) begin : g_two
      assign clr = second_i && armed_q;
    end else begin : g_one
      assign clr = stat_rd_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (set_i) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (clr) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (stat_rd_i) begin
      armed_q <= TWO_STEP && flag_q;
    end
  end

  assign flag_o = flag_q;

  assert_set_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);

  generate
    if (TWO_STEP) begin : g_chk_two
      // R7/R10: without a qualifying second access the flag cannot drop
      assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !second_i) |=> flag_o);
    end else begin : g_chk_one
      assert_rd_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_rd_i && !set_i) |=> !flag_o);
    end
  endgenerate
endmodule

// File: rtl/spi_ctrl_fields.sv
module spi_ctrl_fields
  import spi_flag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic              irq_en_o,
  output logic [LEN_W-1:0]  xfer_len_o
);
  localparam logic [LEN_CODE_W-1:0] CODE_MIN = LEN_CODE_W'(8);
  localparam logic [LEN_W-1:0] LEN_DEF = LEN_W'(8);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(16);

  logic                  ie_q, len_en_q;
  logic [LEN_CODE_W-1:0] code_q;
  logic                  unused_wbits;

  assign unused_wbits = ^{wdata_i[CTRL_W-1:CB_LEN_LO+LEN_CODE_W],
                          wdata_i[CB_IE-1:CB_LEN_EN+1],
                          wdata_i[CB_LEN_EN-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q     <= 1'b0;
      len_en_q <= 1'b0;
      code_q   <= '0;
    end else if (wr_en_i) begin
      ie_q     <= wdata_i[CB_IE];
      len_en_q <= wdata_i[CB_LEN_EN];
      code_q   <= wdata_i[CB_LEN_LO +: LEN_CODE_W];
    end
  end

  always_comb begin
    xfer_len_o = LEN_DEF;
    if (len_en_q) begin
      if (code_q == '0)           xfer_len_o = LEN_MAX;
      else if (code_q >= CODE_MIN) xfer_len_o = LEN_W'(code_q);
    end
  end

  assign irq_en_o = ie_q;

  assert_len_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_len_o >= LEN_DEF) && (xfer_len_o <= LEN_MAX));
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
  import spi_flag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              ev_abort_i,
  input  logic              ev_modf_i,
  input  logic              ev_ovr_i,
  input  logic              ev_wcol_i,
  input  logic              ev_done_i,
  output logic [7:0]        status_o,
  output logic              irq_o,
  output logic [LEN_W-1:0]  xfer_len_o
);
  localparam logic [NFLAG-1:0] TWO_MASK = NFLAG'((1 << F_MODF) | (1 << F_WCOL) | (1 << F_DONE));

  logic             stat_rd, ctrl_wr, data_acc, irq_en;
  logic [NFLAG-1:0] ev, second, flags;

  assign stat_rd  = sel_i && rd_i && (addr_i == REG_STAT);
  assign ctrl_wr  = sel_i && wr_i && (addr_i == REG_CTRL);
  assign data_acc = sel_i && (rd_i || wr_i) && (addr_i == REG_DATA);

  assign ev = {ev_done_i, ev_wcol_i, ev_ovr_i, ev_modf_i, ev_abort_i};

  always_comb begin
    second         = '0;
    second[F_MODF] = ctrl_wr;
    second[F_WCOL] = data_acc;
    second[F_DONE] = data_acc;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    spi_flag_cell #(.TWO_STEP(TWO_MASK[i])) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (ev[i]),
      .stat_rd_i(stat_rd),
      .second_i (second[i]),
      .flag_o   (flags[i])
    );
  end

  spi_ctrl_fields u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (ctrl_wr),
    .wdata_i   (wdata_i),
    .irq_en_o  (irq_en),
    .xfer_len_o(xfer_len_o)
  );

  assign status_o = {flags, 3'b000};
  assign irq_o    = irq_en && (flags[F_DONE] || flags[F_MODF]);

  assert_irq_on_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en && ev_done_i && !ctrl_wr) |=> irq_o);
  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2:0] == 3'b000);
endmodule

// File: tb/spi_flag_unit_test.sv
module spi_flag_unit_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 0, rd = 0, wr = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [4:0]  ev = 0;  // {done,wcol,ovr,modf,abort}
  logic [7:0]  status;
  logic        irq;
  logic [4:0]  xlen;
  int          total = 0, bad = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  spi_flag_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata),
    .ev_abort_i(ev[0]), .ev_modf_i(ev[1]), .ev_ovr_i(ev[2]),
    .ev_wcol_i(ev[3]), .ev_done_i(ev[4]),
    .status_o(status), .irq_o(irq), .xfer_len_o(xlen));

  localparam logic [7:0] M_ABRT = 8'h08, M_MODF = 8'h10, M_OVR = 8'h20,
                         M_WCOL = 8'h40, M_DONE = 8'h80;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all helpers start and end at a negedge
  task automatic pulse(logic [4:0] m);
    ev = m; @(negedge clk); ev = 0;
  endtask
  task automatic acc(logic [1:0] a, logic r, logic w, logic [15:0] d);
    sel = 1; addr = a; rd = r; wr = w; wdata = d;
    @(negedge clk); sel = 0; rd = 0; wr = 0;
  endtask
  task automatic stat_rd(output logic [7:0] v);
    sel = 1; addr = 0; rd = 1; #1 v = status;
    @(negedge clk); sel = 0; rd = 0;
  endtask

  task automatic t_reset;
    chk("R1 status", status, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 len", xlen, 8);
  endtask

  task automatic t_layout;
    logic [7:0] v;
    pulse(5'b00001); chk("R2 abort bit3", status, M_ABRT);
    pulse(5'b00010); chk("R2 modf bit4", status, M_ABRT|M_MODF);
    pulse(5'b00100); pulse(5'b01000); pulse(5'b10000);
    chk("R2 all flags", status, 8'hF8);
    repeat (3) @(negedge clk);
    chk("R3 sticky", status, 8'hF8);
    stat_rd(v);
    chk("R4 read returns pre-clear", v, 8'hF8);
    chk("R4 abort/ovr cleared", status, M_MODF|M_WCOL|M_DONE);
    acc(2'd1, 0, 1, 16'h0000); chk("R5 modf clears after rd+ctrl wr", status, M_WCOL|M_DONE);
    acc(2'd2, 1, 0, 16'h0000); chk("R6 wcol/done clear after rd+data rd", status, 8'h00);
  endtask

  task automatic t_no_prior_read;
    logic [7:0] v;
    pulse(5'b11010);
    acc(2'd1, 0, 1, 16'h0000); chk("R5 ctrl wr alone keeps modf", status, M_MODF|M_WCOL|M_DONE);
    acc(2'd2, 0, 1, 16'h0000); chk("R6 data wr alone keeps flags", status, M_MODF|M_WCOL|M_DONE);
    stat_rd(v);
    acc(2'd2, 0, 1, 16'h1234); chk("R6 data wr after rd clears", status, M_MODF);
    acc(2'd1, 0, 1, 16'h0000); chk("R5 armed survives data access", status, 8'h00);
  endtask

  task automatic t_race;
    logic [7:0] v;
    pulse(5'b01000);
    stat_rd(v);
    ev = 5'b01000; sel = 1; addr = 2; rd = 1;
    @(negedge clk); ev = 0; sel = 0; rd = 0;
    chk("R7 set beats clear", status, M_WCOL);
    acc(2'd2, 1, 0, 16'h0000); chk("R7 disarmed after race", status, M_WCOL);
    pulse(5'b00001);
    ev = 5'b00001; stat_rd(v); ev = 0;
    chk("R7 abort set beats read", status, M_WCOL|M_ABRT);
    stat_rd(v);
    acc(2'd2, 1, 0, 16'h0000); chk("R7 clears after fresh read", status, 8'h00);
  endtask

  task automatic t_unarmed;
    logic [7:0] v;
    stat_rd(v);
    pulse(5'b10010);
    acc(2'd1, 0, 1, 16'h0000);
    acc(2'd2, 1, 0, 16'h0000);
    chk("R10 read of zero flag does not arm", status, M_MODF|M_DONE);
    stat_rd(v); acc(2'd1, 0, 1, 16'h0000); acc(2'd2, 1, 0, 16'h0000);
    chk("R10 cleanup", status, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    pulse(5'b10000); chk("R8 no irq with enable 0", irq, 0);
    acc(2'd1, 0, 1, 16'h0080); chk("R8 irq with enable and done", irq, 1);
    stat_rd(v); acc(2'd2, 1, 0, 16'h0000); chk("R8 irq drops", irq, 0);
    pulse(5'b01101); chk("R8 abort/ovr/wcol no irq", irq, 0);
    pulse(5'b00010); chk("R8 irq on modf", irq, 1);
    stat_rd(v); acc(2'd1, 0, 1, 16'h0080); chk("R8 irq drops with modf", irq, 0);
    acc(2'd2, 1, 0, 16'h0000); chk("R8 cleanup", status, 8'h00);
  endtask

  task automatic t_len;
    for (int c = 0; c < 16; c++) begin
      int exp;
      exp = (c == 0) ? 16 : (c >= 8 ? c : 8);
      acc(2'd1, 0, 1, 16'(c << 8) | 16'h0004);
      chk($sformatf("R9 len code %0d", c), xlen, exp);
    end
    acc(2'd1, 0, 1, 16'h0B00); chk("R9 bit2 clear gives 8", xlen, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1; @(negedge clk);
    t_reset;
    t_layout;
    t_no_prior_read;
    t_race;
    t_unarmed;
    t_irq;
    t_len;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule